// File: doc/BRIEF.md
# Flash Security Lock Access Controller

This block is the gatekeeper between the flash array and whoever wants to touch it. Three nonvolatile lock bits are decoded into a protection state for each of the two flash blocks: unlocked, soft locked or hard locked. The same bits also give an overall security level from 1 to 4. Every flash command is either granted or ignored. A command comes from in-application programming (code running on the chip) or from an external programming host. Code reads by the running program go through the same gate. A read that the gate blocks returns all-ones instead of array data.

Protection has two tiers. A soft-locked block can still be erased, programmed and verified, but only by in-application commands issued from code that itself runs in a locked block. A hard-locked block refuses everything except a full chip erase. The block also keeps the working copy of the lock bits. That copy is loaded from the nonvolatile value at reset. Programming can only clear its bits, and a granted chip erase sets them all again.

Top module: `flash_lock_ctrl`

## Requirements
- R1: The lock bits are written {first, second, third} = lock_status_o[2:0], with 0 meaning programmed (P) and 1 meaning unprogrammed (U). The block states decode as follows, written Block 1 / Block 0: UUU none/none; PUU and UPU soft/soft; UUP and PPU hard/soft; UPP, PUP and PPP hard/hard. The state encoding is 0 none, 1 soft, 2 hard. Block 0 is never hard unless Block 1 is hard.
- R2: level_o gives the security level minus one. UUU is 0. PUU and UPU are 1. PPP is 3. Every other pattern is 2.
- R3: A command strobe (cmd_valid_i) is answered on the next clock edge with exactly one of grant_o or ignore_o, each a one-cycle pulse. With no strobe, both are low. Reserved code 7 is always ignored. Command codes: 0 code read, 1 byte verify, 2 byte program, 3 sector erase, 4 block erase, 5 chip erase, 6 lock-bit program.
- R4: Commands 0 to 4 aimed at an unlocked block are granted in either mode.
- R5: Verify, program and erase commands (1 to 4) aimed at a hard-locked block are ignored in both modes.
- R6: In in-application mode (host_mode_i=0), commands 0 to 4 aimed at a soft-locked block are granted when the block named by exec_blk_i is locked.
- R7: In external host mode (host_mode_i=1), a soft-locked target is handled as hard locked, so commands 0 to 4 to it are ignored.
- R8: A code read of a hard-locked block is granted only in in-application mode and only from a hard-locked executing block. A granted read or verify returns the rd_data_i sampled at the strobe. Any other answered command returns 8'hFF.
- R9: At level 4 (PPP), reads and verifies are ignored whatever the executing block, and boot_ext_ok_o is low. At all other levels it is high.
- R10: Lock-bit program (6) is always granted and clears exactly the bits set in lock_mask_i. It never sets a bit.
- R11: Chip erase (5) is always granted, even at level 4. It pulses erase_all_o for one cycle and returns all three lock bits to 1.
- R12: While rst_n is low, the lock bits are loaded from nv_lock_i, grant_o, ignore_o and erase_all_o are low, and rd_data_o is 8'hFF.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset; loads the lock bits |
| nv_lock_i | input | 3 | Nonvolatile lock-bit value {first, second, third} |
| cmd_valid_i | input | 1 | Command strobe |
| cmd_i | input | 3 | Command code |
| tgt_blk_i | input | 1 | Target block (1 = Block 1) |
| exec_blk_i | input | 1 | Block the requesting code executes from |
| host_mode_i | input | 1 | 1 = external host, 0 = in-application |
| lock_mask_i | input | 3 | Bits to program for a lock-bit program command |
| rd_data_i | input | 8 | Array data for the addressed byte |
| grant_o | output | 1 | Command granted (one-cycle pulse) |
| ignore_o | output | 1 | Command ignored (one-cycle pulse) |
| rd_data_o | output | 8 | Read data, or 8'hFF when masked |
| erase_all_o | output | 1 | Chip erase performed (one-cycle pulse) |
| lock_status_o | output | 3 | Current lock bits |
| blk1_state_o | output | 2 | Block 1 protection state |
| blk0_state_o | output | 2 | Block 0 protection state |
| level_o | output | 2 | Security level minus one |
| boot_ext_ok_o | output | 1 | External boot permitted |

## Verification
All eight lock patterns are loaded through reset, one at a time. This separates the two level-2 patterns from the level-3 patterns that program just one bit, and the hard/soft pairs from the hard/hard pairs. Code reads of a hard block from a soft block and from a hard block are tried side by side. This shows the executing block is taken into account. At level 4 the same read must still be refused. The same soft-block command is sent once in each mode to expose the host-mode promotion. Random commands, targets, modes, masks and lock states then mix lock programming and chip erase with ordinary traffic. This checks that lock-bit updates feed the very next decision.

// File: rtl/flk_pkg.sv
package flk_pkg;
  typedef enum logic [1:0] {
    LK_NONE = 2'd0,
    LK_SOFT = 2'd1,
    LK_HARD = 2'd2
  } lk_state_e;

  typedef enum logic [2:0] {
    OP_READ       = 3'd0,
    OP_VERIFY     = 3'd1,
    OP_PROG       = 3'd2,
    OP_SECT_ERASE = 3'd3,
    OP_BLK_ERASE  = 3'd4,
    OP_CHIP_ERASE = 3'd5,
    OP_LOCK_PROG  = 3'd6,
    OP_RSVD       = 3'd7
  } op_e;

  localparam int LOCK_W = 3;
  localparam int NBLK   = 2;

  typedef struct packed {
    lk_state_e  blk1;
    lk_state_e  blk0;
    logic [1:0] level;
  } lk_view_t;

  // bits = {first, second, third}; a 0 is a programmed bit
  function automatic lk_view_t lk_decode(input logic [LOCK_W-1:0] bits);
    lk_view_t v;
    unique case (bits)
      3'b111:  v = '{blk1: LK_NONE, blk0: LK_NONE, level: 2'd0};
      3'b011:  v = '{blk1: LK_SOFT, blk0: LK_SOFT, level: 2'd1};
      3'b101:  v = '{blk1: LK_SOFT, blk0: LK_SOFT, level: 2'd1};
      3'b110:  v = '{blk1: LK_HARD, blk0: LK_SOFT, level: 2'd2};
      3'b001:  v = '{blk1: LK_HARD, blk0: LK_SOFT, level: 2'd2};
      3'b100:  v = '{blk1: LK_HARD, blk0: LK_HARD, level: 2'd2};
      3'b010:  v = '{blk1: LK_HARD, blk0: LK_HARD, level: 2'd2};
      default: v = '{blk1: LK_HARD, blk0: LK_HARD, level: 2'd3};
    endcase
    return v;
  endfunction

  function automatic logic lk_permit(input op_e op, input lk_state_e tgt_st,
                                     input lk_state_e exe_st, input logic host,
                                     input logic [1:0] level);
    lk_state_e eff;
    if (op == OP_CHIP_ERASE || op == OP_LOCK_PROG) return 1'b1;
    if (op == OP_RSVD) return 1'b0;
    if (level == 2'd3 && (op == OP_READ || op == OP_VERIFY)) return 1'b0;
    eff = (host && tgt_st == LK_SOFT) ? LK_HARD : tgt_st;
    unique case (eff)
      LK_NONE: return 1'b1;
      LK_SOFT: return (op == OP_READ) || (exe_st != LK_NONE);
      default: return (op == OP_READ) && !host && (exe_st == LK_HARD);
    endcase
  endfunction
endpackage

// File: rtl/flk_lock_reg.sv
module flk_lock_reg
  import flk_pkg::*;
(
  input  logic              clk,
  input  logic              rst_n,
  input  logic [LOCK_W-1:0] nv_i,
  input  logic              clr_all_i,
  input  logic              pgm_en_i,
  input  logic [LOCK_W-1:0] pgm_mask_i,
  output logic [LOCK_W-1:0] bits_o
);
  logic [LOCK_W-1:0] bits_q;

  always_ff @(posedge clk) begin
    if (!rst_n)         bits_q <= nv_i;
    else if (clr_all_i) bits_q <= '1;
    else if (pgm_en_i)  bits_q <= bits_q & ~pgm_mask_i;
  end

  assign bits_o = bits_q;
endmodule

// File: rtl/flk_decode.sv
module flk_decode
  import flk_pkg::*;
(
  input  logic [LOCK_W-1:0] bits_i,
  output lk_state_e         st_o [NBLK],
  output logic [1:0]        level_o
);
  lk_view_t view;

  assign view = lk_decode(bits_i);

  for (genvar g = 0; g < NBLK; g++) begin : g_blk
    if (g == 0) begin : g_b0
      assign st_o[g] = view.blk0;
    end else begin : g_b1
      assign st_o[g] = view.blk1;
    end
  end

  assign level_o = view.level;
endmodule

// File: rtl/flk_gate.sv
module flk_gate
  import flk_pkg::*;
#(
  parameter int DATA_W = 8
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              valid_i,
  input  op_e               op_i,
  input  lk_state_e         tgt_st_i,
  input  lk_state_e         exe_st_i,
  input  logic              host_i,
  input  logic [1:0]        level_i,
  input  logic [DATA_W-1:0] rd_data_i,
  output logic              permit_o,
  output logic              grant_o,
  output logic              ignore_o,
  output logic              erase_o,
  output logic [DATA_W-1:0] rd_data_o
);
  localparam logic [DATA_W-1:0] FILL = '1;

  logic is_rd;

  assign permit_o = lk_permit(op_i, tgt_st_i, exe_st_i, host_i, level_i);
  assign is_rd    = (op_i == OP_READ) || (op_i == OP_VERIFY);

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      grant_o   <= 1'b0;
      ignore_o  <= 1'b0;
      erase_o   <= 1'b0;
      rd_data_o <= FILL;
    end else begin
      grant_o  <= valid_i && permit_o;
      ignore_o <= valid_i && !permit_o;
      erase_o  <= valid_i && permit_o && (op_i == OP_CHIP_ERASE);
      if (valid_i) rd_data_o <= (permit_o && is_rd) ? rd_data_i : FILL;
    end
  end
endmodule

// File: rtl/flash_lock_ctrl.sv
module flash_lock_ctrl
  import flk_pkg::*;
#(
  parameter int DATA_W = 8
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic [2:0]        nv_lock_i,
  input  logic              cmd_valid_i,
  input  logic [2:0]        cmd_i,
  input  logic              tgt_blk_i,
  input  logic              exec_blk_i,
  input  logic              host_mode_i,
  input  logic [2:0]        lock_mask_i,
  input  logic [DATA_W-1:0] rd_data_i,
  output logic              grant_o,
  output logic              ignore_o,
  output logic [DATA_W-1:0] rd_data_o,
  output logic              erase_all_o,
  output logic [2:0]        lock_status_o,
  output logic [1:0]        blk1_state_o,
  output logic [1:0]        blk0_state_o,
  output logic [1:0]        level_o,
  output logic              boot_ext_ok_o
);
  op_e               op;
  logic              permit_w;
  logic              chip_clr_w;
  logic              lock_pgm_w;
  logic [LOCK_W-1:0] bits_w;
  lk_state_e         blk_st [NBLK];
  logic [1:0]        level_w;

  assign op         = op_e'(cmd_i);
  assign chip_clr_w = cmd_valid_i && permit_w && (op == OP_CHIP_ERASE);
  assign lock_pgm_w = cmd_valid_i && permit_w && (op == OP_LOCK_PROG);

  flk_lock_reg u_lock (
    .clk       (clk),
    .rst_n     (rst_n),
    .nv_i      (nv_lock_i),
    .clr_all_i (chip_clr_w),
    .pgm_en_i  (lock_pgm_w),
    .pgm_mask_i(lock_mask_i),
    .bits_o    (bits_w)
  );

  flk_decode u_dec (
    .bits_i (bits_w),
    .st_o   (blk_st),
    .level_o(level_w)
  );

  flk_gate #(.DATA_W(DATA_W)) u_gate (
    .clk      (clk),
    .rst_n    (rst_n),
    .valid_i  (cmd_valid_i),
    .op_i     (op),
    .tgt_st_i (blk_st[tgt_blk_i]),
    .exe_st_i (blk_st[exec_blk_i]),
    .host_i   (host_mode_i),
    .level_i  (level_w),
    .rd_data_i(rd_data_i),
    .permit_o (permit_w),
    .grant_o  (grant_o),
    .ignore_o (ignore_o),
    .erase_o  (erase_all_o),
    .rd_data_o(rd_data_o)
  );

  assign lock_status_o = bits_w;
  assign blk1_state_o  = blk_st[1];
  assign blk0_state_o  = blk_st[0];
  assign level_o       = level_w;
  assign boot_ext_ok_o = (level_w != 2'd3);
endmodule

// File: rtl/flk_checker.sv
module flk_checker #(
  parameter int DATA_W = 8
) (
  input logic              clk,
  input logic              rst_n,
  input logic              cmd_valid_i,
  input logic [2:0]        cmd_i,
  input logic              tgt_blk_i,
  input logic              host_mode_i,
  input logic              grant_o,
  input logic              ignore_o,
  input logic [DATA_W-1:0] rd_data_o,
  input logic              erase_all_o,
  input logic [2:0]        lock_status_o,
  input logic [1:0]        blk1_state_o,
  input logic [1:0]        blk0_state_o,
  input logic [1:0]        level_o,
  input logic              boot_ext_ok_o
);
  logic [1:0] tgt_st;
  assign tgt_st = tgt_blk_i ? blk1_state_o : blk0_state_o;

  a_r3_one_answer: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0({grant_o, ignore_o}));

  a_r3_quiet: assert property (@(posedge clk) disable iff (!rst_n)
    !cmd_valid_i |=> (!grant_o && !ignore_o));

  a_r5_hard_reject: assert property (@(posedge clk) disable iff (!rst_n)
    (cmd_valid_i && tgt_st == 2'd2 && cmd_i >= 3'd1 && cmd_i <= 3'd4) |=> ignore_o);

  a_r7_host_soft: assert property (@(posedge clk) disable iff (!rst_n)
    (cmd_valid_i && host_mode_i && tgt_st != 2'd0 && cmd_i <= 3'd4) |=> ignore_o);

  a_r8_masked: assert property (@(posedge clk) disable iff (!rst_n)
    ignore_o |-> (rd_data_o == '1));

  a_r9_top_level: assert property (@(posedge clk) disable iff (!rst_n)
    (level_o == 2'd3) |-> (!boot_ext_ok_o && blk1_state_o == 2'd2 && blk0_state_o == 2'd2));

  a_r1_hard_pair: assert property (@(posedge clk) disable iff (!rst_n)
    (blk0_state_o == 2'd2) |-> (blk1_state_o == 2'd2));

  a_r10_one_way: assert property (@(posedge clk) disable iff (!rst_n)
    !(cmd_valid_i && cmd_i == 3'd5) |=> ((lock_status_o & ~$past(lock_status_o)) == 3'd0));

  a_r11_chip_erase: assert property (@(posedge clk) disable iff (!rst_n)
    (cmd_valid_i && cmd_i == 3'd5) |=> (grant_o && erase_all_o && lock_status_o == 3'b111));
endmodule

bind flash_lock_ctrl flk_checker #(.DATA_W(DATA_W)) u_chk (
  .clk          (clk),
  .rst_n        (rst_n),
  .cmd_valid_i  (cmd_valid_i),
  .cmd_i        (cmd_i),
  .tgt_blk_i    (tgt_blk_i),
  .host_mode_i  (host_mode_i),
  .grant_o      (grant_o),
  .ignore_o     (ignore_o),
  .rd_data_o    (rd_data_o),
  .erase_all_o  (erase_all_o),
  .lock_status_o(lock_status_o),
  .blk1_state_o (blk1_state_o),
  .blk0_state_o (blk0_state_o),
  .level_o      (level_o),
  .boot_ext_ok_o(boot_ext_ok_o)
);

// File: tb/sim_flash_lock_ctrl.sv
module sim_flash_lock_ctrl;
  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic [2:0] nv_lock = 3'b111;
  logic       cmd_valid = 1'b0;
  logic [2:0] cmd = 3'd0;
  logic       tgt_blk = 1'b0;
  logic       exec_blk = 1'b0;
  logic       host_mode = 1'b0;
  logic [2:0] lock_mask = 3'd0;
  logic [7:0] rd_data_in = 8'd0;
  logic       grant, ignore, erase_all, boot_ok;
  logic [7:0] rd_data;
  logic [2:0] lock_status;
  logic [1:0] blk1_st, blk0_st, level;

  int n_tests = 0;
  int n_fail  = 0;
  logic [2:0] mdl_bits = 3'b111;

  always #10 clk = ~clk;

  flash_lock_ctrl u0 (
    .clk(clk), .rst_n(rst_n), .nv_lock_i(nv_lock), .cmd_valid_i(cmd_valid),
    .cmd_i(cmd), .tgt_blk_i(tgt_blk), .exec_blk_i(exec_blk), .host_mode_i(host_mode),
    .lock_mask_i(lock_mask), .rd_data_i(rd_data_in), .grant_o(grant), .ignore_o(ignore),
    .rd_data_o(rd_data), .erase_all_o(erase_all), .lock_status_o(lock_status),
    .blk1_state_o(blk1_st), .blk0_state_o(blk0_st), .level_o(level), .boot_ext_ok_o(boot_ok)
  );

  // expected block state from individual programmed bits
  function automatic logic [1:0] m_state(input logic blk1, input logic [2:0] b);
    logic f, s, t, hard;
    f = !b[2]; s = !b[1]; t = !b[0];
    hard = blk1 ? (t || (f && s)) : (t && (f || s));
    if (hard) return 2'd2;
    if (f || s || t) return 2'd1;
    return 2'd0;
  endfunction

  function automatic logic [1:0] m_level(input logic [2:0] b);
    int n;
    n = (!b[2]) + (!b[1]) + (!b[0]);
    if (n == 0) return 2'd0;
    if (n == 3) return 2'd3;
    if (n == 1 && b[0]) return 2'd1;
    return 2'd2;
  endfunction

  function automatic logic m_allow(input logic [2:0] op, input logic [2:0] b,
                                   input logic tg, input logic ex, input logic hm);
    logic [1:0] ts, es;
    if (op == 3'd5 || op == 3'd6) return 1'b1;
    if (op == 3'd7) return 1'b0;
    ts = m_state(tg, b);
    es = m_state(ex, b);
    if (op <= 3'd1 && m_level(b) == 2'd3) return 1'b0;
    if (ts == 2'd0) return 1'b1;
    if (hm) return 1'b0;
    if (ts == 2'd2) return (op == 3'd0) && (es == 2'd2);
    return (op == 3'd0) || (es != 2'd0);
  endfunction

  function automatic string m_tag(input logic [2:0] op, input logic [2:0] b,
                                  input logic tg, input logic hm);
    logic [1:0] ts;
    ts = m_state(tg, b);
    if (op == 3'd5) return "R11";
    if (op == 3'd6) return "R10";
    if (op == 3'd7) return "R3";
    if (op <= 3'd1 && m_level(b) == 2'd3) return "R9";
    if (op == 3'd0 && ts == 2'd2) return "R8";
    if (ts == 2'd0) return "R4";
    if (hm) return "R7";
    if (ts == 2'd2) return "R5";
    return "R6";
  endfunction

  task automatic chk(input logic ok, input string tag, input string what,
                     input int act, input int exp);
    n_tests++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s %s: actual %0h expected %0h", tag, what, act, exp);
    end
  endtask

  task automatic check_view(input string tag);
    chk(lock_status == mdl_bits, tag, "lock_status", lock_status, mdl_bits);
    chk(blk1_st == m_state(1'b1, mdl_bits), "R1", "blk1_state", blk1_st, m_state(1'b1, mdl_bits));
    chk(blk0_st == m_state(1'b0, mdl_bits), "R1", "blk0_state", blk0_st, m_state(1'b0, mdl_bits));
    chk(level == m_level(mdl_bits), "R2", "level", level, m_level(mdl_bits));
    chk(boot_ok == (mdl_bits != 3'b000), "R9", "boot_ext_ok", boot_ok, mdl_bits != 3'b000);
  endtask

  task automatic do_reset(input logic [2:0] nv);
    @(negedge clk);
    rst_n = 1'b0;
    nv_lock = nv;
    cmd_valid = 1'b0;
    repeat (2) @(posedge clk);
    #1;
    chk(!grant && !ignore && !erase_all, "R12", "pulses in reset", {grant, ignore, erase_all}, 0);
    chk(rd_data == 8'hFF, "R12", "rd_data in reset", rd_data, 8'hFF);
    @(negedge clk);
    rst_n = 1'b1;
    mdl_bits = nv;
    #1;
    check_view("R12");
  endtask

  task automatic do_op(input logic [2:0] op, input logic tg, input logic ex,
                       input logic hm, input logic [2:0] mask);
    logic  exp_g;
    logic [7:0] exp_d;
    string tag;
    @(negedge clk);
    cmd = op; tgt_blk = tg; exec_blk = ex; host_mode = hm; lock_mask = mask;
    rd_data_in = 8'($urandom);
    cmd_valid = 1'b1;
    exp_g = m_allow(op, mdl_bits, tg, ex, hm);
    tag   = m_tag(op, mdl_bits, tg, hm);
    exp_d = (exp_g && op <= 3'd1) ? rd_data_in : 8'hFF;
    if (exp_g && op == 3'd5) mdl_bits = 3'b111;
    else if (exp_g && op == 3'd6) mdl_bits = mdl_bits & ~mask;
    @(posedge clk);
    #1;
    chk(grant == exp_g, tag, "grant", grant, exp_g);
    chk(ignore == !exp_g, tag, "ignore", ignore, !exp_g);
    chk(rd_data == exp_d, (op <= 3'd1) ? "R8" : tag, "rd_data", rd_data, exp_d);
    chk(erase_all == (exp_g && op == 3'd5), "R11", "erase_all", erase_all, exp_g && op == 3'd5);
    check_view((op == 3'd5) ? "R11" : "R10");
    @(negedge clk);
    cmd_valid = 1'b0;
    @(posedge clk);
    #1;
    chk(!grant && !ignore && !erase_all, "R3", "idle pulses", {grant, ignore, erase_all}, 0);
  endtask

  initial begin
    #(20 * 200000);
    n_fail++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
    $finish;
  end

  initial begin
    void'($urandom(32'd20240611));
    // R1 R2 R12: every pattern through reset
    for (int p = 0; p < 8; p++) do_reset(3'(p));

    do_reset(3'b111);
    do_op(3'd2, 1'b0, 1'b0, 1'b0, 3'd0);       // R4 program unlocked
    do_op(3'd0, 1'b1, 1'b0, 1'b1, 3'd0);       // R4 host read unlocked
    do_op(3'd7, 1'b0, 1'b0, 1'b0, 3'd0);       // R3 reserved

    do_reset(3'b011);                          // soft/soft
    do_op(3'd4, 1'b0, 1'b1, 1'b0, 3'd0);       // R6 granted from locked block
    do_op(3'd4, 1'b0, 1'b1, 1'b1, 3'd0);       // R7 same in host mode
    do_op(3'd1, 1'b1, 1'b0, 1'b0, 3'd0);       // R6 verify

    do_reset(3'b110);                          // hard/soft
    do_op(3'd0, 1'b1, 1'b0, 1'b0, 3'd0);       // R8 from soft: masked
    do_op(3'd0, 1'b1, 1'b1, 1'b0, 3'd0);       // R8 from hard: data
    do_op(3'd0, 1'b1, 1'b1, 1'b1, 3'd0);       // R8 host: masked
    do_op(3'd2, 1'b1, 1'b1, 1'b0, 3'd0);       // R5 program hard
    do_op(3'd3, 1'b0, 1'b1, 1'b0, 3'd0);       // R6 sector erase soft

    do_reset(3'b000);                          // level 4
    do_op(3'd0, 1'b1, 1'b1, 1'b0, 3'd0);       // R9 read refused
    do_op(3'd1, 1'b0, 1'b1, 1'b0, 3'd0);       // R9 verify refused
    do_op(3'd5, 1'b0, 1'b0, 1'b1, 3'd0);       // R11 chip erase

    do_op(3'd6, 1'b0, 1'b0, 1'b0, 3'b001);     // R10 clear third
    do_op(3'd6, 1'b0, 1'b0, 1'b0, 3'b100);     // R10 clear first
    do_op(3'd6, 1'b0, 1'b0, 1'b0, 3'b111);     // R10 to level 4

    for (int i = 0; i < 800; i++) begin
      logic [2:0] op;
      if ($urandom_range(0, 39) == 0) do_reset(3'($urandom));
      op = 3'($urandom);
      if (op == 3'd5 && $urandom_range(0, 3) != 0) op = 3'd2;
      do_op(op, 1'($urandom), 1'($urandom), 1'($urandom), 3'($urandom));
    end

    $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
    $finish;
  end
endmodule